// File: doc/BRIEF.md
# Exception Vector Priority Arbiter

This block watches nineteen hardware exception and interrupt request lines and decides which one the CPU services next. It presents the winner as an even byte address in the vector area; the CPU reads the two-byte handler start address stored there. Each request pulse is latched into a sticky pending flag. The flag is cleared when the CPU acknowledges that source, or when software writes a one to the matching bit of the clear input.

Arbitration works in two stages. Two top sources always win, and the lower vector breaks a tie between them. The first is system reset at vector 0x00 and the second is the zero-divide trap at vector 0x02. Next comes the watchdog at vector 0x04, which cannot be masked. The sixteen maskable sources sit below it and are grouped seven ways. Each group has a programmable 2-bit level. A maskable source can compete only if its enable bit is set and its group level is above the CPU's current mask level. Among the sources that can compete, the highest level wins. Sources with equal levels are ordered by vector address, and the lowest vector wins. Vector 0x26 and the software vectors from 0x28 upward are never generated.

Top module: `vec_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, all pending flags are cleared. After that edge `vec_valid` is 0 and `vec_addr` is 0x00.
- R2: A one-cycle pulse on `req[i]` sets the flag of source i at that edge. The flag stays set, with no further pulse, until an acknowledge or a clear removes it. The arbitration result that includes the new flag is visible after the same edge.
- R3: The vector is twice the source index. Reset is 0 (0x00), zero divide 1 (0x02) and watchdog 2 (0x04). Timer1 is 3 (0x06) and timer0 4 (0x08). The K10/K11 input group is 5 (0x0A), the K04–K07 group 6 (0x0C) and the K00–K03 group 7 (0x0E). The serial error, receive and transmit sources are 8, 9 and 10 (0x10, 0x12, 0x14). Stopwatch 100/10/1 Hz are 11 to 13 (0x16 to 0x1A). Clock timer 32/8/2/1 Hz are 14 to 17 (0x1C to 0x22). The ADC is 18 (0x24). `vec_addr` is always even and never exceeds 0x24.
- R4: Reset and zero divide win over every other pending source, whatever the enables, levels and mask are. Reset wins over zero divide.
- R5: The watchdog ignores the enables, levels and mask. It wins over every maskable source and loses only to the sources in R4.
- R6: Maskable source i (index 3 to 18) uses enable bit `irq_en[i-3]`. Its group level is `grp_lvl[2g+1:2g]`. The groups are: g0 indices 3–4, g1 index 5, g2 indices 6–7, g3 indices 8–10, g4 indices 11–13, g5 indices 14–17 and g6 index 18. The source competes only if its enable bit is 1 and its group level is greater than `cpu_mask`, so level 0 never competes.
- R7: Between competing maskable sources, the higher group level wins, whatever their vector order.
- R8: Between competing sources of equal rank, the lowest vector wins.
- R9: If `ack` is high at an edge while `vec_valid` is 1, that edge clears only the flag of the presented source. The output shows the next winner after that same edge. If `ack` is high while `vec_valid` is 0, it has no effect.
- R10: A 1 on bit i of `flag_clr` clears flag i at the edge. If `req[i]` and `flag_clr[i]` are both high at the same edge, the request wins and the flag stays set.
- R11: If no source is competing, `vec_valid` is 0 and `vec_addr` is 0x00. Pending flags that cannot compete stay set. They are presented once their enable, level or the mask allows it, and this takes effect after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 19 | One-cycle request pulses, bit = source index |
| flag_clr | input | 19 | Write-one-to-clear strobes for the pending flags |
| irq_en | input | 16 | Enables of the maskable sources 3 to 18 |
| grp_lvl | input | 14 | Seven 2-bit group priority levels |
| cpu_mask | input | 2 | Current CPU interrupt mask level |
| ack | input | 1 | CPU acknowledge of the presented vector |
| vec_valid | output | 1 | A source is selected |
| vec_addr | output | 8 | Even vector address of the selected source |

## Verification
The bench uses the default 2-bit level width and the 8-bit vector width. With 2-bit levels the watchdog's rank sits just one step above the highest programmable level, so a level-3 group competing against the watchdog tests that boundary directly. With `cpu_mask` at 3, every maskable group is blocked; with `cpu_mask` at 2, only level-3 groups can compete. Both settings are exercised, together with level-0 groups and cleared enables. The 8-bit vector width covers the whole hardware range up to 0x24, which lets the bench confirm that the ADC vector is the top end.

// File: rtl/vecarb_pkg.sv
// Package: shared constants and the fixed source-to-group map of the
// exception vector arbiter. Assumes the hardware vector order is fixed.
package vecarb_pkg;

    localparam int NSRC       = 19;  // hardware sources, vectors 0x00..0x24
    localparam int FIRST_MASK = 3;   // first maskable source index
    localparam int NMASK      = NSRC - FIRST_MASK;
    localparam int NGRP       = 7;
    localparam int IDX_W      = $clog2(NSRC);

    // Group number of a maskable source index (unused for indices below 3).
    function automatic int grp_of(input int idx);
        if (idx <= 4)       return 0;  // programmable timers
        else if (idx == 5)  return 1;  // K1x inputs
        else if (idx <= 7)  return 2;  // K0x inputs
        else if (idx <= 10) return 3;  // serial
        else if (idx <= 13) return 4;  // stopwatch
        else if (idx <= 17) return 5;  // clock timer
        else                return 6;  // ADC
    endfunction

endpackage

// File: rtl/vecarb_flags.sv
// Module: sticky pending flags. A request sets a flag; acknowledge or
// clear strobes reset it; set wins over clear in the same cycle.
// Exposes the next-state flags so arbitration sees this edge's changes.
module vecarb_flags #(
    parameter int N = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] flag_clr,
    input  logic [N-1:0] ack_hit,
    output logic [N-1:0] flag_nxt
);
    logic [N-1:0] flag_q;

    // Next-state of the flags: keep, drop cleared ones, add new requests.
    always_comb flag_nxt = (flag_q & ~flag_clr & ~ack_hit) | req;

    // Flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_nxt;
    end
endmodule

// File: rtl/vecarb_pick.sv
// Module: combinational two-stage picker. Gives every source a rank
// (0 = not competing), then takes the highest rank with the lowest index.
// Assumes cpu_mask and grp_lvl are the same width.
module vecarb_pick
    import vecarb_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  logic [NSRC-1:0]       pend,
    input  logic [NMASK-1:0]      irq_en,
    input  logic [NGRP*LVL_W-1:0] grp_lvl,
    input  logic [LVL_W-1:0]      cpu_mask,
    output logic                  any,
    output logic [IDX_W-1:0]      win_idx
);
    localparam int RANK_W = LVL_W + 1;
    localparam logic [RANK_W-1:0] NMI_RANK = RANK_W'(1 << LVL_W);
    localparam logic [RANK_W-1:0] TOP_RANK = RANK_W'((1 << LVL_W) + 1);

    logic [RANK_W-1:0] rank [NSRC];

    for (genvar i = 0; i < NSRC; i++) begin : g_rank
        if (i < 2) begin : g_top
            // Reset and zero divide: unconditional top rank.
            assign rank[i] = pend[i] ? TOP_RANK : '0;
        end else if (i == 2) begin : g_nmi
            // Watchdog: non-maskable, just above every programmable level.
            assign rank[i] = pend[i] ? NMI_RANK : '0;
        end else begin : g_mask
            localparam int G = grp_of(i);
            logic [LVL_W-1:0] lvl;
            assign lvl = grp_lvl[G*LVL_W +: LVL_W];
            // Maskable: enabled and group level above the CPU mask.
            assign rank[i] = (pend[i] && irq_en[i-FIRST_MASK] && (lvl > cpu_mask))
                             ? {1'b0, lvl} : '0;
        end
    end

    // Highest rank wins; scanning downward with >= favours lower indices.
    always_comb begin
        logic [RANK_W-1:0] best;
        best    = '0;
        any     = 1'b0;
        win_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (rank[i] != '0 && rank[i] >= best) begin
                best    = rank[i];
                win_idx = IDX_W'(i);
                any     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vec_arbiter.sv
// Module: exception vector priority arbiter top. Latches requests,
// arbitrates on next-state flags and registers the winning even vector.
// Assumes ack is only meaningful while vec_valid is high.
module vec_arbiter
    import vecarb_pkg::*;
#(
    parameter int LVL_W = 2,
    parameter int VEC_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       req,
    input  logic [NSRC-1:0]       flag_clr,
    input  logic [NMASK-1:0]      irq_en,
    input  logic [NGRP*LVL_W-1:0] grp_lvl,
    input  logic [LVL_W-1:0]      cpu_mask,
    input  logic                  ack,
    output logic                  vec_valid,
    output logic [VEC_W-1:0]      vec_addr
);
    logic [NSRC-1:0]  ack_hit;
    logic [NSRC-1:0]  pend;
    logic             any;
    logic [IDX_W-1:0] win_idx;
    logic [IDX_W-1:0] idx_q;

    // Acknowledge targets only the source currently presented.
    always_comb ack_hit = (ack && vec_valid) ? (NSRC'(1) << idx_q) : '0;

    vecarb_flags #(.N(NSRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .flag_clr (flag_clr),
        .ack_hit  (ack_hit),
        .flag_nxt (pend)
    );

    vecarb_pick #(.LVL_W(LVL_W)) u_pick (
        .pend     (pend),
        .irq_en   (irq_en),
        .grp_lvl  (grp_lvl),
        .cpu_mask (cpu_mask),
        .any      (any),
        .win_idx  (win_idx)
    );

    // Output register: winner index and valid, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            idx_q     <= '0;
        end else begin
            vec_valid <= any;
            idx_q     <= any ? win_idx : '0;
        end
    end

    assign vec_addr = {{(VEC_W-IDX_W-1){1'b0}}, idx_q, 1'b0};
endmodule

// File: rtl/vecarb_chk.sv
// Module: property checker for vec_arbiter, attached with bind.
// Assumes the reset request is source 0 and the watchdog is source 2.
module vecarb_chk #(
    parameter int N     = 19,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_addr
);
    // R3: presented vectors are even and within the hardware range.
    p_even_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr[0] == 1'b0 && vec_addr <= VEC_W'(36)));

    // R11: idle output is address zero.
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> vec_addr == '0);

    // R4: a reset request is presented right after its edge.
    p_reset_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |=> (vec_valid && vec_addr == '0));

    // R4: zero divide is beaten only by reset.
    p_zdiv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req[1] |=> (vec_valid && vec_addr <= VEC_W'(2)));

    // R5: watchdog beats every maskable source.
    p_nmi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req[2] |=> (vec_valid && vec_addr <= VEC_W'(4)));
endmodule

bind vec_arbiter vecarb_chk #(.N(vecarb_pkg::NSRC), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr)
);

// File: tb/sim_vec_arbiter.sv
module sim_vec_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] req = '0;
    logic [18:0] flag_clr = '0;
    logic [15:0] irq_en = '0;
    logic [13:0] grp_lvl = '0;
    logic [1:0]  cpu_mask = '0;
    logic        ack = 1'b0;
    logic        vec_valid;
    logic [7:0]  vec_addr;

    int n_chk = 0;
    int n_bad = 0;

    vec_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .flag_clr(flag_clr),
        .irq_en(irq_en), .grp_lvl(grp_lvl), .cpu_mask(cpu_mask),
        .ack(ack), .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    always #4 clk = ~clk;

    localparam int NT = 15;
    localparam logic [18:0] T_REQ [NT] = '{
        19'h00010, 19'h00018, 19'h40008, 19'h7FFF8, 19'h40000,
        19'h00010, 19'h00020, 19'h00020, 19'h40004, 19'h00004,
        19'h00006, 19'h40007, 19'h00700, 19'h00080, 19'h40002};
    localparam logic [15:0] T_EN [NT] = '{
        16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h7FFF,
        16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000,
        16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000};
    localparam logic [13:0] T_LVL [NT] = '{
        14'h1555, 14'h1555, 14'h3555, 14'h2AAA, 14'h1555,
        14'h1554, 14'h2AAA, 14'h3FFF, 14'h3FFF, 14'h0000,
        14'h1555, 14'h1555, 14'h1555, 14'h1555, 14'h3FFF};
    localparam logic [1:0] T_MASK [NT] = '{
        2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
        2'd0, 2'd2, 2'd2, 2'd0, 2'd3,
        2'd0, 2'd0, 2'd0, 2'd0, 2'd3};
    // Expected {valid, vector}.
    localparam logic [8:0] T_EXP [NT] = '{
        9'h108, 9'h106, 9'h124, 9'h106, 9'h000,
        9'h000, 9'h000, 9'h10A, 9'h104, 9'h104,
        9'h102, 9'h100, 9'h110, 9'h10E, 9'h102};
    localparam string T_TAG [NT] = '{
        "R2", "R8", "R7", "R8", "R6",
        "R6", "R6", "R6", "R5", "R5",
        "R4", "R4", "R8", "R3", "R4"};

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [8:0] exp);
        logic [8:0] act;
        act = {vec_valid, vec_addr};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b vec=0x%02h, expected valid=%0b vec=0x%02h",
                     tag, act[8], act[7:0], exp[8], exp[7:0]);
        end
    endtask

    task automatic clear_all();
        flag_clr = '1;
        step();
        flag_clr = '0;
    endtask

    task automatic pulse(input logic [18:0] r);
        req = r;
        step();
        req = '0;
    endtask

    task automatic ack_once();
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got running, expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state, with requests pulsed during reset.
        req = 19'h7FFFF;
        repeat (3) step();
        req = '0;
        step();
        chk("R1 reset", 9'h000);
        rst_n = 1'b1;
        step();
        chk("R1 after reset, no flags", 9'h000);

        // Table of single-shot arbitration cases (R2..R8).
        for (int t = 0; t < NT; t++) begin
            irq_en   = T_EN[t];
            grp_lvl  = T_LVL[t];
            cpu_mask = T_MASK[t];
            clear_all();
            pulse(T_REQ[t]);
            chk(T_TAG[t], T_EXP[t]);
        end

        // R2: a flag is sticky over idle cycles.
        irq_en = '1; grp_lvl = 14'h1555; cpu_mask = 2'd0;
        clear_all();
        pulse(19'h01000);
        repeat (6) step();
        chk("R2 sticky stopwatch 10Hz", 9'h118);

        // R9: acknowledge walks the pending set.
        clear_all();
        pulse(19'h40008);
        chk("R9 first winner", 9'h106);
        ack_once();
        chk("R9 after first ack", 9'h124);
        ack_once();
        chk("R9 after second ack", 9'h000);

        // R9: acknowledge while nothing is valid leaves the flags alone.
        irq_en = '0;
        clear_all();
        pulse(19'h40000);
        chk("R11 disabled flag not shown", 9'h000);
        ack_once();
        irq_en = '1;
        step();
        chk("R9 ack ignored when idle, R11 flag kept", 9'h124);

        // R10: write-one-to-clear, and set wins over clear.
        clear_all();
        pulse(19'h40008);
        flag_clr = 19'h00008;
        step();
        flag_clr = '0;
        chk("R10 clear presented flag", 9'h124);
        flag_clr = 19'h40000;
        req      = 19'h40000;
        step();
        flag_clr = '0;
        req      = '0;
        chk("R10 request wins over clear", 9'h124);

        // R11: mask change takes effect after the next edge.
        cpu_mask = 2'd1;
        step();
        chk("R11 masked by cpu level", 9'h000);
        cpu_mask = 2'd0;
        step();
        chk("R11 unmasked again", 9'h124);

        // R1: reset in mid-operation clears everything.
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk("R1 reset mid-run", 9'h000);

        finish_run();
    end
endmodule